// File: doc/BRIEF.md
# Double-Data-Rate Burst Data Path

This block joins a single-data-rate word interface inside the chip to a double-rate pin interface. For a write burst it takes one 2n-bit word per clock and puts it on the n-bit pin bus as two halves: the lower half while the clock is high and the upper half while the clock is low. Each half carries its own mask bits, and a set mask bit tells the receiver not to store that half. While the burst runs, the block drives the data strobe from a quadrature clock. Each strobe edge therefore falls in the middle of a half-cycle data window.

For a read burst the strobe is an input. The block captures one n-bit half on each strobe edge and joins the two halves into one 2n-bit word, which it presents on the clock after the pin cycle. The strobe is taken as already shifted to the centre of the data eye. That delay, and all electrical concerns, are outside this block. A burst length chosen at the start fixes how many internal words a burst lasts.

The control state machine has three states. IDLE moves to WRITE on a write start and to READ on a read start. A write start wins when both are present. WRITE and READ return to IDLE on the edge where the word counter reaches the last index latched for the burst. In every other case they stay put and the counter advances.

Top module: `ddr_burst_path`

## Requirements
- R1: While reset is held and after it is released, busy, pin_dq_oe, pin_dqs_oe and rd_valid are 0, and pin_dq_out and pin_dqs_out are 0.
- R2: When busy is 0 and wr_start is 1 at a rising clock edge, busy, pin_dq_oe and pin_dqs_oe become 1 from that edge on. The wr_word and wr_mask present at that edge form the first transfer.
- R3: During a write cycle, pin_dq_out carries wr_word bits [n-1:0] while clk is high and bits [2n-1:n] while clk is low. pin_dm_out carries wr_mask[0] while clk is high and wr_mask[1] while clk is low. A mask value of 1 marks that half as blocked.
- R4: During a write, pin_dqs_out equals clk_q, so it is high from the middle of the high phase to the middle of the low phase. Outside writes, pin_dq_oe and pin_dqs_oe are 0 and pin_dq_out, pin_dm_out and pin_dqs_out are 0.
- R5: blen_sel selects the burst length in pin transfers: 0 gives 2, 1 gives 4, and 2 or 3 give 8. A burst lasts that many transfers divided by two clock cycles. For k from 1 upward, write word k is sampled at the k-th rising edge after the start edge.
- R6: In a read cycle, the pin_dq_in value at a rising pin_dqs_in edge becomes rd_word[n-1:0] and the value at a falling edge becomes rd_word[2n-1:n]. The joined word appears with rd_valid = 1 in the clock cycle that follows the pin cycle.
- R7: A read burst gives rd_valid = 1 for exactly burst-length/2 consecutive cycles and then rd_valid returns to 0. The pin drivers stay disabled throughout the read.
- R8: While busy is 1, wr_start, rd_start and changes of blen_sel have no effect. The running burst keeps the length latched at its start and ends on time.
- R9: If wr_start and rd_start are both 1 at an edge where busy is 0, a write burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; its phases select the half on the pins |
| clk_q | input | 1 | Copy of clk delayed by a quarter period |
| rst_n | input | 1 | Asynchronous active-low reset |
| blen_sel | input | 2 | Burst length code, latched at start |
| wr_start | input | 1 | Start a write burst |
| wr_word | input | 2*HALF_W | Internal write word |
| wr_mask | input | 2*DM_W | Mask for the lower and upper halves |
| rd_start | input | 1 | Start a read burst |
| rd_word | output | 2*HALF_W | Joined read word |
| rd_valid | output | 1 | rd_word holds a new word |
| busy | output | 1 | A burst is running |
| pin_dq_out | output | HALF_W | Pin data driven on writes |
| pin_dm_out | output | DM_W | Pin mask driven on writes |
| pin_dq_oe | output | 1 | Enable for the data and mask drivers |
| pin_dqs_out | output | 1 | Strobe driven on writes |
| pin_dqs_oe | output | 1 | Enable for the strobe driver |
| pin_dq_in | input | HALF_W | Pin data received on reads |
| pin_dqs_in | input | 1 | Strobe received on reads |

## Verification
Write results appear on the pins in the cycle right after the start edge. The lower half is read 7 ns after each rising edge, when clk_q has just risen, and the upper half 17 ns after it, when clk_q has just fallen. The next word is driven 2 ns after each edge, well before the edge that samples it. A read word is due one clock after the cycle in which the bench puts its halves on the pins, so rd_word and rd_valid are checked 7 ns after that following edge. The cycle after that is checked to confirm that rd_valid has dropped. In both directions, busy going low is checked one cycle after the last transfer, and this also confirms that stray starts and length changes injected during the burst had no effect.

// File: rtl/ddr_bp_pkg.sv
package ddr_bp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bp_state_t;

    localparam int BP_MAX_WORDS = 4;
    localparam int BP_CNT_W     = $clog2(BP_MAX_WORDS);

    // Index of the last internal word for a burst length code:
    // code 0 -> 2 transfers (1 word), 1 -> 4 (2 words), 2/3 -> 8 (4 words).
    function automatic logic [BP_CNT_W-1:0] burst_last(input logic [1:0] sel);
        logic [BP_CNT_W-1:0] r;
        unique case (sel)
            2'd0:    r = BP_CNT_W'(0);
            2'd1:    r = BP_CNT_W'(1);
            default: r = BP_CNT_W'(BP_MAX_WORDS - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ddr_bp_ctrl.sv
module ddr_bp_ctrl
    import ddr_bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_start,
    input  logic       rd_start,
    input  logic [1:0] blen_sel,
    output logic       wr_load,
    output logic       wr_active,
    output logic       rd_active,
    output logic       busy
);

    bp_state_t             state_q, state_d;
    logic [BP_CNT_W-1:0]   cnt_q;
    logic [BP_CNT_W-1:0]   last_q;
    logic                  at_last;

    assign at_last = (cnt_q == last_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start)      state_d = ST_WRITE;
                else if (rd_start) state_d = ST_READ;
            end
            ST_WRITE, ST_READ: begin
                if (at_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // word counter and latched burst length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cnt_q  <= '0;
            last_q <= burst_last(blen_sel);
        end else if (!at_last) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_active = (state_q == ST_WRITE);
        rd_active = (state_q == ST_READ);
        busy      = (state_q != ST_IDLE);
        wr_load   = ((state_q == ST_IDLE) && wr_start) ||
                    ((state_q == ST_WRITE) && !at_last);
    end

endmodule

// File: rtl/ddr_bp_wr_serial.sv
module ddr_bp_wr_serial #(
    parameter int HALF_W = 8,
    parameter int DM_W   = 1
) (
    input  logic                clk,
    input  logic                clk_q,
    input  logic                rst_n,
    input  logic                load,
    input  logic                active,
    input  logic [2*HALF_W-1:0] word,
    input  logic [2*DM_W-1:0]   mask,
    output logic [HALF_W-1:0]   dq_out,
    output logic [DM_W-1:0]     dm_out,
    output logic                dq_oe,
    output logic                dqs_out,
    output logic                dqs_oe
);

    // half 0 goes out in the high phase, half 1 in the low phase
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] d_q;
        logic [DM_W-1:0]   m_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                m_q <= '0;
            end else if (load) begin
                d_q <= word[h*HALF_W +: HALF_W];
                m_q <= mask[h*DM_W +: DM_W];
            end
        end
    end

    always_comb begin
        dq_out  = '0;
        dm_out  = '0;
        if (active) begin
            dq_out = clk ? g_half[0].d_q : g_half[1].d_q;
            dm_out = clk ? g_half[0].m_q : g_half[1].m_q;
        end
        dqs_out = active & clk_q;
        dq_oe   = active;
        dqs_oe  = active;
    end

endmodule

// File: rtl/ddr_bp_rd_capture.sv
module ddr_bp_rd_capture #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dqs_in,
    input  logic [HALF_W-1:0]   dq_in,
    input  logic                capture_en,
    output logic [2*HALF_W-1:0] word,
    output logic                valid
);

    logic [HALF_W-1:0] rise_q;
    logic [HALF_W-1:0] fall_q;

    always_ff @(posedge dqs_in or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= dq_in;
    end

    always_ff @(negedge dqs_in or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= dq_in;
    end

    // join the two halves of the pin cycle that just ended
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture_en;
            if (capture_en) word <= {fall_q, rise_q};
        end
    end

endmodule

// File: rtl/ddr_burst_path.sv
module ddr_burst_path #(
    parameter int HALF_W = 8,
    parameter int DM_W   = 1
) (
    input  logic                clk,
    input  logic                clk_q,
    input  logic                rst_n,
    input  logic [1:0]          blen_sel,
    input  logic                wr_start,
    input  logic [2*HALF_W-1:0] wr_word,
    input  logic [2*DM_W-1:0]   wr_mask,
    input  logic                rd_start,
    output logic [2*HALF_W-1:0] rd_word,
    output logic                rd_valid,
    output logic                busy,
    output logic [HALF_W-1:0]   pin_dq_out,
    output logic [DM_W-1:0]     pin_dm_out,
    output logic                pin_dq_oe,
    output logic                pin_dqs_out,
    output logic                pin_dqs_oe,
    input  logic [HALF_W-1:0]   pin_dq_in,
    input  logic                pin_dqs_in
);

    logic wr_load, wr_active, rd_active;

    ddr_bp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_start  (wr_start),
        .rd_start  (rd_start),
        .blen_sel  (blen_sel),
        .wr_load   (wr_load),
        .wr_active (wr_active),
        .rd_active (rd_active),
        .busy      (busy)
    );

    ddr_bp_wr_serial #(.HALF_W(HALF_W), .DM_W(DM_W)) u_wr (
        .clk     (clk),
        .clk_q   (clk_q),
        .rst_n   (rst_n),
        .load    (wr_load),
        .active  (wr_active),
        .word    (wr_word),
        .mask    (wr_mask),
        .dq_out  (pin_dq_out),
        .dm_out  (pin_dm_out),
        .dq_oe   (pin_dq_oe),
        .dqs_out (pin_dqs_out),
        .dqs_oe  (pin_dqs_oe)
    );

    ddr_bp_rd_capture #(.HALF_W(HALF_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .dqs_in     (pin_dqs_in),
        .dq_in      (pin_dq_in),
        .capture_en (rd_active),
        .word       (rd_word),
        .valid      (rd_valid)
    );

endmodule

// File: rtl/ddr_bp_checker.sv
module ddr_bp_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_start,
    input logic rd_start,
    input logic busy,
    input logic pin_dq_oe,
    input logic pin_dqs_oe,
    input logic rd_valid
);

    logic [2:0] oe_run;
    logic [2:0] rv_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
            rv_run <= '0;
        end else begin
            oe_run <= pin_dq_oe ? oe_run + 3'd1 : 3'd0;
            rv_run <= rd_valid  ? rv_run + 3'd1 : 3'd0;
        end
    end

    assert_wr_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !busy) |=> (pin_dq_oe && pin_dqs_oe && busy));

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_start || rd_start));

    assert_no_drive_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!pin_dq_oe && !pin_dqs_oe));

    assert_rd_start_listens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !wr_start && !busy) |=> (busy && !pin_dq_oe));

    assert_write_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_dq_oe |-> (oe_run < 3'd4));

    assert_read_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rv_run < 3'd4));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pin_dq_oe && wr_start) |=> !pin_dq_oe);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && rd_start && !busy) |=> pin_dq_oe);

endmodule

bind ddr_burst_path ddr_bp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .rd_start   (rd_start),
    .busy       (busy),
    .pin_dq_oe  (pin_dq_oe),
    .pin_dqs_oe (pin_dqs_oe),
    .rd_valid   (rd_valid)
);

// File: tb/ddr_burst_path_bench.sv
`timescale 1ns/1ps
module ddr_burst_path_bench;

    localparam int HW = 8;
    localparam int DW = 1;

    logic          clk = 1'b0;
    logic          clk_q = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    blen_sel = 2'd0;
    logic          wr_start = 1'b0;
    logic [2*HW-1:0] wr_word = '0;
    logic [2*DW-1:0] wr_mask = '0;
    logic          rd_start = 1'b0;
    logic [2*HW-1:0] rd_word;
    logic          rd_valid;
    logic          busy;
    logic [HW-1:0] pin_dq_out;
    logic [DW-1:0] pin_dm_out;
    logic          pin_dq_oe;
    logic          pin_dqs_out;
    logic          pin_dqs_oe;
    logic [HW-1:0] pin_dq_in = '0;
    logic          pin_dqs_in;
    logic          rd_win = 1'b0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;
    initial begin
        #5;
        forever #10 clk_q = ~clk_q;
    end
    assign pin_dqs_in = rd_win & clk_q;

    ddr_burst_path #(.HALF_W(HW), .DM_W(DW)) u_ddr_burst_path (
        .clk(clk), .clk_q(clk_q), .rst_n(rst_n), .blen_sel(blen_sel),
        .wr_start(wr_start), .wr_word(wr_word), .wr_mask(wr_mask),
        .rd_start(rd_start), .rd_word(rd_word), .rd_valid(rd_valid),
        .busy(busy), .pin_dq_out(pin_dq_out), .pin_dm_out(pin_dm_out),
        .pin_dq_oe(pin_dq_oe), .pin_dqs_out(pin_dqs_out),
        .pin_dqs_oe(pin_dqs_oe), .pin_dq_in(pin_dq_in),
        .pin_dqs_in(pin_dqs_in)
    );

    function automatic int words_of(input logic [1:0] sel);
        return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_pins(input string req);
        chk(pin_dq_oe == 1'b0 && pin_dqs_oe == 1'b0, req, {pin_dq_oe, pin_dqs_oe}, 0);
        chk(pin_dq_out == '0 && pin_dm_out == '0 && pin_dqs_out == 1'b0, req,
            {pin_dq_out, pin_dm_out, pin_dqs_out}, 0);
    endtask

    // write burst; junk=1 injects starts and length changes while busy (R8)
    task automatic do_write(input logic [1:0] sel, input bit junk, input bit both);
        int n;
        logic [2*HW-1:0] w [4];
        logic [2*DW-1:0] m [4];
        n = words_of(sel);
        for (int i = 0; i < 4; i++) begin
            w[i] = 16'($urandom);
            m[i] = 2'($urandom);
        end
        @(posedge clk); #2;
        wr_start = 1'b1; rd_start = both; blen_sel = sel;
        wr_word = w[0]; wr_mask = m[0];
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            if (k + 1 < n) begin
                wr_word = w[k+1]; wr_mask = m[k+1];
            end else begin
                wr_word = 16'($urandom); wr_mask = 2'($urandom);
            end
            wr_start = junk ? 1'($urandom) : 1'b0;
            rd_start = junk ? 1'($urandom) : 1'b0;
            if (junk) blen_sel = 2'($urandom);
            #5;
            // R2 drivers enabled; R3 lower half and mask bit 0 in high phase
            chk(busy && pin_dq_oe && pin_dqs_oe, both ? "R9" : "R2",
                {busy, pin_dq_oe, pin_dqs_oe}, 3'b111);
            chk(pin_dq_out == w[k][HW-1:0], "R3", pin_dq_out, w[k][HW-1:0]);
            chk(pin_dm_out == m[k][0], "R3", pin_dm_out, m[k][0]);
            chk(pin_dqs_out == 1'b1, "R4", pin_dqs_out, 1);
            #10;
            // R3 upper half and mask bit 1 in low phase; R4 strobe low
            chk(pin_dq_out == w[k][2*HW-1:HW], "R3", pin_dq_out, w[k][2*HW-1:HW]);
            chk(pin_dm_out == m[k][1], "R3", pin_dm_out, m[k][1]);
            chk(pin_dqs_out == 1'b0, "R4", pin_dqs_out, 0);
        end
        @(posedge clk); #2;
        wr_start = 1'b0; rd_start = 1'b0;
        #5;
        // R5 burst ended after n cycles; R8 junk had no effect
        chk(busy == 1'b0, junk ? "R8" : "R5", busy, 0);
        idle_pins("R4");
    endtask

    task automatic do_read(input logic [1:0] sel, input bit junk);
        int n;
        logic [2*HW-1:0] w [4];
        n = words_of(sel);
        for (int i = 0; i < 4; i++) w[i] = 16'($urandom);
        @(posedge clk); #2;
        rd_start = 1'b1; wr_start = 1'b0; blen_sel = sel;
        for (int k = 0; k <= n; k++) begin
            @(posedge clk); #2;
            if (k < n) begin
                pin_dq_in = w[k][HW-1:0];
                rd_win = 1'b1;
                rd_start = junk ? 1'($urandom) : 1'b0;
                wr_start = junk ? 1'($urandom) : 1'b0;
                if (junk) blen_sel = 2'($urandom);
            end else begin
                rd_win = 1'b0;
                rd_start = 1'b0; wr_start = 1'b0;
            end
            #5;
            if (k == 0) begin
                chk(rd_valid == 1'b0, "R6", rd_valid, 0);
            end else begin
                chk(rd_valid == 1'b1, "R7", rd_valid, 1);
                chk(rd_word == w[k-1], "R6", rd_word, w[k-1]);
            end
            idle_pins("R7");
            #5;
            if (k < n) pin_dq_in = w[k][2*HW-1:HW];
        end
        @(posedge clk); #7;
        chk(rd_valid == 1'b0, junk ? "R8" : "R7", rd_valid, 0);
        chk(busy == 1'b0, "R7", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #45;
        // R1 during reset
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1", {busy, rd_valid}, 0);
        idle_pins("R1");
        @(posedge clk); #2; rst_n = 1'b1;
        @(posedge clk); #7;
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1", {busy, rd_valid}, 0);
        idle_pins("R1");
        // directed: every length code, both directions
        for (int s = 0; s < 4; s++) begin
            do_write(2'(s), 1'b0, 1'b0);
            do_read(2'(s), 1'b0);
        end
        // R9 simultaneous starts
        do_write(2'd1, 1'b0, 1'b1);
        do_write(2'd0, 1'b0, 1'b1);
        // R8 directed: shortest burst with junk, longest with junk
        do_write(2'd0, 1'b1, 1'b0);
        do_read(2'd3, 1'b1);
        // random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 2) do_write(2'($urandom), 1'($urandom), 1'b0);
            else              do_read(2'($urandom), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule